// File: doc/BRIEF.md
# Multi-timer tick enable generator

This block gives five timer channels their count enables. Everything runs on one fast peripheral clock. The outputs are one-cycle enable strobes, not derived clocks, so every downstream timer stays in the same clock domain and simply counts on cycles where its strobe is high.

Two programmable prescalers turn the peripheral clock into slower strobes:

- Prescaler group 0 serves channels 0 and 1.
- Prescaler group 1 serves channels 2, 3 and 4.

Each channel has one 4-bit code. The code either divides its group's prescaled strobe by a fixed power of two, or routes that group's external tick input to the channel. Because one code carries both the source and the ratio, both change in a single write. The external ticks are asynchronous. They are synchronized with two flops and edge-detected before use.

A small write port loads the configuration. Address 0 holds both prescaler values. Address 1 holds the five channel codes. Any write restarts the divider chain, so the new rate takes effect from a known phase.

Each channel decodes its code into one of five modes:

| Mode | Meaning |
|------|---------|
| CH_DIV2 | divide the group strobe by 2 |
| CH_DIV4 | divide the group strobe by 4 |
| CH_DIV8 | divide the group strobe by 8 |
| CH_DIV16 | divide the group strobe by 16 |
| CH_EXT | pass the group's external tick |

There are two kinds of transition:

- A configuration write moves a channel to the mode decoded from its new code.
- Reset sends every channel to CH_DIV2.

In the divide modes, a divide counter advances on each group strobe and wraps at ratio minus one. That wrap is the fire transition.

Top module: `tick_enable_gen`

## Requirements
- R1: Prescaler g produces a strobe once every P+1 cycles, where P is its 8-bit value. P=0 gives a strobe on every cycle. At address 0, bits 7:0 hold P for group 0 and bits 15:8 hold P for group 1.
- R2: Channels 0 and 1 take prescaler group 0 and external tick input 0. Channels 2, 3 and 4 take prescaler group 1 and external tick input 1.
- R3: Channel c's code sits at bits 4c+3:4c of address 1. Codes 0, 1, 2 and 3 divide the group strobe by 2, 4, 8 and 16. The channel's tick period is therefore ratio × (P+1) cycles.
- R4: Codes 5 to 15 behave exactly like code 3, which divides by 16.
- R5: Code 4 selects the group's external tick input. A rising edge on that input produces a tick_o pulse of exactly one cycle. The pulse is high in the cycle after the third rising clock edge following the input change. A falling edge produces no tick.
- R6: Any configuration write restarts every prescaler and divide counter. In the cycle after the one that follows the write edge, no divide-mode channel ticks. The first tick appears after the N-th clock edge following the write edge, where N is the channel's period, and ticks repeat every N cycles after that.
- R7: While rst_n is low, tick_o is all zero and the configuration clears to zero. After release, every channel ticks every second cycle.
- R8: A tick_o bit is never high on two consecutive cycles, except in the cycle that follows a configuration write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the prescaler register, 1 selects the channel code register |
| cfg_wdata | input | 32 | Write data |
| ext_tick_i | input | 2 | Asynchronous external tick inputs, one per group |
| tick_o | output | 5 | One-cycle tick enables, one per channel |

## Verification
Some behaviours are checked by assertions on every cycle:

- the spacing of each prescaler's strobes against the programmed value;
- the one-cycle width of ticks;
- the quiet cycle after a write;
- the exact correspondence between a detected external edge and the tick of every channel in external mode.

Other behaviours can only be shown by the bench's sweeps. These are:

- the absolute tick periods for each code and prescaler pair;
- the phase of the first tick after a write;
- the aliasing of the high codes;
- the group wiring of the shared inputs;
- the three-cycle latency of the synchronizer.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int NUM_GRP  = 2;
    localparam int FLD_W    = 4;
    localparam int DIV_CW   = 4;
    localparam logic [FLD_W-1:0] EXT_CODE = 4'd4;

    typedef enum logic [2:0] {
        CH_DIV2,
        CH_DIV4,
        CH_DIV8,
        CH_DIV16,
        CH_EXT
    } ch_mode_e;

    function automatic ch_mode_e decode_code(input logic [FLD_W-1:0] code);
        ch_mode_e m;
        unique case (code)
            4'd0:     m = CH_DIV2;
            4'd1:     m = CH_DIV4;
            4'd2:     m = CH_DIV8;
            EXT_CODE: m = CH_EXT;
            default:  m = CH_DIV16;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] limit,
    output logic            stb
);
    logic [PS_W-1:0] cnt_q;

    assign stb = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_ext_sync.sv
module tick_ext_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tick_channel.sv
module tick_channel
    import tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [FLD_W-1:0] code,
    input  logic             ps_stb,
    input  logic             ext_rise,
    output logic             tick
);
    ch_mode_e          mode;
    logic [DIV_CW-1:0] lim;
    logic [DIV_CW-1:0] dcnt_q;
    logic              wrap;
    logic              tick_d;

    assign mode = decode_code(code);

    // Output decode: terminal count per mode and the selected strobe.
    always_comb begin
        unique case (mode)
            CH_DIV2:  lim = 4'd1;
            CH_DIV4:  lim = 4'd3;
            CH_DIV8:  lim = 4'd7;
            CH_DIV16: lim = 4'd15;
            CH_EXT:   lim = 4'd0;
            default:  lim = 4'd15;
        endcase
        wrap   = ps_stb && (dcnt_q == lim);
        tick_d = (mode == CH_EXT) ? ext_rise : wrap;
    end

    // Divide counter state register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            dcnt_q <= '0;
        end else if (mode != CH_EXT && ps_stb) begin
            dcnt_q <= wrap ? '0 : dcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= tick_d;
        end
    end
endmodule

// File: rtl/tick_enable_gen.sv
module tick_enable_gen
    import tick_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int GRP0_CH = 2,
    parameter int PS_W    = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [NUM_GRP-1:0] ext_tick_i,
    output logic [NUM_CH-1:0]  tick_o
);
    localparam int PS_BITS  = NUM_GRP * PS_W;
    localparam int FLD_BITS = NUM_CH * FLD_W;

    logic [PS_BITS-1:0]  ps_cfg_q;
    logic [FLD_BITS-1:0] fld_cfg_q;
    logic [NUM_GRP-1:0]  ps_stb;
    logic [NUM_GRP-1:0]  ext_rise;
    logic                restart;

    assign restart = cfg_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_cfg_q  <= '0;
            fld_cfg_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == 1'b0) begin
                ps_cfg_q <= cfg_wdata[PS_BITS-1:0];
            end else begin
                fld_cfg_q <= cfg_wdata[FLD_BITS-1:0];
            end
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_ps
        tick_prescaler #(.PS_W(PS_W)) u_ps (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .limit   (ps_cfg_q[g*PS_W +: PS_W]),
            .stb     (ps_stb[g])
        );
    end

    tick_ext_sync #(.N(NUM_GRP)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_tick_i),
        .rise    (ext_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        tick_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .code     (fld_cfg_q[c*FLD_W +: FLD_W]),
            .ps_stb   (ps_stb[GRP]),
            .ext_rise (ext_rise[GRP]),
            .tick     (tick_o[c])
        );
    end
endmodule

// File: rtl/tick_enable_gen_chk.sv
module tick_enable_gen_chk
    import tick_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int GRP0_CH = 2,
    parameter int PS_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [NUM_CH-1:0]         tick_o,
    input logic [NUM_GRP-1:0]        ps_stb,
    input logic [NUM_GRP-1:0]        ext_rise,
    input logic [NUM_GRP*PS_W-1:0]   ps_cfg,
    input logic [NUM_CH*FLD_W-1:0]   fld_cfg
);
    logic [NUM_CH-1:0] div_mask;
    logic [PS_W-1:0]   gap_q [NUM_GRP];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            div_mask[c] = (fld_cfg[c*FLD_W +: FLD_W] != EXT_CODE);
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_gap
        always_ff @(posedge clk) begin
            if (!rst_n || cfg_we || ps_stb[g]) begin
                gap_q[g] <= '0;
            end else begin
                gap_q[g] <= gap_q[g] + 1'b1;
            end
        end

        AST_PS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            ps_stb[g] == (gap_q[g] == ps_cfg[g*PS_W +: PS_W])); // R1
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;

        AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o[c] && !$past(cfg_we)) |=> !tick_o[c]); // R8

        AST_EXT_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!div_mask[c]) |-> (tick_o[c] == $past(ext_rise[GRP]))); // R5
    end

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ##1 ((tick_o & $past(div_mask)) == '0)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (tick_o == '0)); // R7
endmodule

bind tick_enable_gen tick_enable_gen_chk #(
    .NUM_CH  (NUM_CH),
    .GRP0_CH (GRP0_CH),
    .PS_W    (PS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .tick_o   (tick_o),
    .ps_stb   (ps_stb),
    .ext_rise (ext_rise),
    .ps_cfg   (ps_cfg_q),
    .fld_cfg  (fld_cfg_q)
);

// File: tb/tb_tick_enable_gen.sv
module tb_tick_enable_gen;
    localparam int NCH = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic            cfg_addr;
    logic [31:0]     cfg_wdata;
    logic [1:0]      ext_tick_i;
    logic [NCH-1:0]  tick_o;

    int nchecks = 0;
    int nerr    = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    tick_enable_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .ext_tick_i (ext_tick_i),
        .tick_o     (tick_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic int ratio_of(input int code);
        if (code == 4) return 0;
        if (code < 3)  return 2 << code;
        return 16;
    endfunction

    // Writes prescalers then codes; measures from the last write edge.
    task automatic run_div(input int p0, input int p1, input int codes[NCH], input string req);
        int per [NCH];
        int bad [NCH];
        int maxn;
        int win;
        int quiet;
        logic [31:0] w;
        maxn  = 0;
        quiet = 0;
        w     = '0;
        for (int c = 0; c < NCH; c++) begin
            per[c] = ratio_of(codes[c]) * (((c < 2) ? p0 : p1) + 1);
            bad[c] = 0;
            if (per[c] > maxn) maxn = per[c];
            w[4*c +: 4] = 4'(codes[c]);
        end
        cfg_write(1'b0, {16'h0, 8'(p1), 8'(p0)});
        cfg_write(1'b1, w);
        win = (maxn == 0) ? 40 : 2 * maxn + 1;
        for (int j = 2; j <= win; j++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                bit exp;
                exp = (per[c] != 0) && (((j - 1) % per[c]) == 0);
                if (tick_o[c] !== exp) bad[c]++;
                if (j == 2 && per[c] != 0 && tick_o[c] !== 1'b0) quiet++;
            end
        end
        check(quiet == 0, $sformatf("R6 quiet after write p0=%0d p1=%0d", p0, p1), quiet, 0);
        for (int c = 0; c < NCH; c++) begin
            check(bad[c] == 0,
                  $sformatf("%s ch%0d code=%0d p0=%0d p1=%0d mismatches", req, c, codes[c], p0, p1),
                  bad[c], 0);
        end
    endtask

    // Pulses one external input; all channels are in external mode.
    task automatic ext_pulse(input int idx);
        int bad;
        logic [NCH-1:0] want;
        bad  = 0;
        want = (idx == 0) ? 5'b00011 : 5'b11100;
        @(negedge clk);
        ext_tick_i[idx] = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (tick_o !== ((k == 3) ? want : '0)) bad++;
            if (k == 5) ext_tick_i[idx] = 1'b0;
        end
        check(bad == 0, $sformatf("R5 R2 external input %0d edge response", idx), bad, 0);
    endtask

    initial begin
        int codes [NCH];
        int list  [NCH];
        int pv0   [3];
        int pv1   [3];
        int rcnt;
        int rbad;
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_addr   = 1'b0;
        cfg_wdata  = '0;
        ext_tick_i = '0;

        // R7 reset state
        rbad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (tick_o !== '0) rbad++;
        end
        check(rbad == 0, "R7 tick_o zero in reset", rbad, 0);
        rst_n = 1'b1;
        rbad  = 0;
        rcnt  = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (tick_o !== (((k % 2) == 0) ? 5'b11111 : 5'b00000)) rbad++;
            if (tick_o[0]) rcnt++;
        end
        check(rbad == 0, "R7 default period 2 after reset", rbad, 0);
        check(rcnt == 4, "R7 default tick count", rcnt, 4);

        // R1 R2 R3 R8 sweep
        pv0  = '{0, 1, 4};
        pv1  = '{0, 2, 3};
        list = '{0, 1, 2, 3, 15};
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int r = 0; r < NCH; r++) begin
                    for (int c = 0; c < NCH; c++) codes[c] = list[(c + r) % NCH];
                    run_div(pv0[a], pv1[b], codes, "R1 R2 R3 R8");
                end
            end
        end

        // R4 aliasing codes
        codes = '{5, 6, 7, 8, 11};
        run_div(1, 0, codes, "R4");
        codes = '{12, 13, 14, 15, 9};
        run_div(0, 2, codes, "R4");

        // R1 largest prescaler value
        codes = '{0, 0, 0, 0, 0};
        run_div(255, 0, codes, "R1 max");

        // R5 external ticks, group wiring
        codes = '{4, 4, 4, 4, 4};
        run_div(0, 0, codes, "R5 idle");
        ext_pulse(0);
        ext_pulse(1);

        // Atomic switch from external back to divide in one write
        codes = '{1, 4, 0, 4, 2};
        run_div(2, 1, codes, "R3 R6 mixed");
        codes = '{0, 0, 0, 0, 0};
        run_div(0, 0, codes, "R3 R6 return");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end
endmodule